// File: doc/BRIEF.md
# Interrupt Sense and Priority Unit

This block sits between a bank of raw interrupt lines and the interrupt logic of a processor. Each line has its own sense setting, which picks one of four codes: level active high, level active low, rising edge or falling edge. It also has an 8-bit priority and an enable bit. Every line passes through a two-flop synchronizer. A level source shows as pending for as long as its line is asserted, after its polarity is applied. An edge source latches a sticky pending bit, which software clears by writing the source number to an acknowledge register.

A single-cycle register port gives access to the packed sense and priority words, the enable and pending words, the acknowledge register and a winner word. Sources below 32 use the local bank. Sources from 32 upward use the common bank, indexed by the source number minus 32. A registered winner output gives the enabled pending source with the largest priority value. Ties go to the lowest source number. The all-ones number means that no source qualifies. The default build has 48 sources. The address map allows up to 160 sources.

Top module: `irqsp_top`

## Requirements
- R1: After reset every sense code is 0 (level high), every priority and enable bit is 0, and the winner output reads valid=0, id=all-ones (63 with 48 sources), prio=0.
- R2: Sense code 0 makes a source pending while its line is 1. Sense code 1 makes it pending while its line is 0.
- R3: Sense code 2 sets a sticky pending bit on a 0-to-1 line transition. The bit stays set while the line returns low, until an acknowledge write names that source.
- R4: Sense code 3 sets the sticky bit on a 1-to-0 transition only. A rising transition leaves it clear.
- R5: A write of a source number to the acknowledge register (word 0x70, number in the low bits) clears only that source's sticky bit. It has no effect on level sources or on other sources.
- R6: Sense codes are 2 bits each, 16 per word. Local source n uses word 0x00+n/16, bits 2(n%16)+1:2(n%16). Common source n uses word 0x20+(n-32)/16 at the same bit offset for (n-32).
- R7: Priorities are 8 bits each, 4 per word, and span 0 to 255. Local source n uses word 0x08+n/4, bits 8(n%4)+7:8(n%4). Common source n uses word 0x40+(n-32)/4.
- R8: The winner is the enabled pending source with the largest priority. A tie goes to the lower source number. With no candidate, id is all-ones and prio is 0.
- R9: Enable bit for source n is word 0x60+n/32, bit n%32. A disabled source never wins, yet its pending bit still reads back at word 0x68+n/32, bit n%32.
- R10: A read issued in one cycle returns the full packed word on rdata after the next clock edge, and rdata holds until the next read. Word 0x71 reads {valid, 15'b0, prio[7:0], id zero-extended to 8 bits}.
- R11: A level line change applied before clock edge k shows on the winner outputs after edge k+2. An edge-mode change shows after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_SRC | Raw interrupt lines, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| top_valid | output | 1 | A qualifying source exists |
| top_id | output | ID_W | Winning source number, all-ones when none |
| top_prio | output | 8 | Winning priority, 0 when none |

## Verification
The checker assumes that a read and a write never target a register in the same cycle. It also assumes that software writes only source numbers below NUM_SRC to the acknowledge register. The sticky-hold property assumes that any write may change the sense mode, so it rests only on cycles with no write at all. The bench drives its strobes one at a time at falling clock edges and changes the interrupt lines only between accesses. It also leaves several cycles after each line change, so every synchronizer stage has settled before any winner or pending value is compared.

// File: rtl/irqsp_pkg.sv
package irqsp_pkg;

    typedef enum logic [1:0] {
        SENSE_HI   = 2'd0,
        SENSE_LO   = 2'd1,
        SENSE_RISE = 2'd2,
        SENSE_FALL = 2'd3
    } sense_e;

    localparam int unsigned LOCAL_SRC = 32;
    localparam int unsigned ADDR_W    = 8;

    localparam logic [ADDR_W-1:0] A_LTRIG = 8'h00;
    localparam logic [ADDR_W-1:0] A_LPRIO = 8'h08;
    localparam logic [ADDR_W-1:0] A_CTRIG = 8'h20;
    localparam logic [ADDR_W-1:0] A_CPRIO = 8'h40;
    localparam logic [ADDR_W-1:0] A_EN    = 8'h60;
    localparam logic [ADDR_W-1:0] A_PEND  = 8'h68;
    localparam logic [ADDR_W-1:0] A_ACK   = 8'h70;
    localparam logic [ADDR_W-1:0] A_TOP   = 8'h71;

    function automatic logic [ADDR_W-1:0] trig_addr(int unsigned src);
        if (src < LOCAL_SRC) return A_LTRIG + ADDR_W'(src / 16);
        return A_CTRIG + ADDR_W'((src - LOCAL_SRC) / 16);
    endfunction

    function automatic logic [ADDR_W-1:0] prio_addr(int unsigned src);
        if (src < LOCAL_SRC) return A_LPRIO + ADDR_W'(src / 4);
        return A_CPRIO + ADDR_W'((src - LOCAL_SRC) / 4);
    endfunction

    function automatic int unsigned bank_idx(int unsigned src);
        return (src < LOCAL_SRC) ? src : src - LOCAL_SRC;
    endfunction

endpackage

// File: rtl/irqsp_cfg_regs.sv
module irqsp_cfg_regs
    import irqsp_pkg::*;
#(
    parameter int unsigned NUM_SRC = 48,
    parameter int unsigned ID_W    = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [31:0]               wdata,
    input  logic [NUM_SRC-1:0]        pend,
    input  logic                      top_valid,
    input  logic [ID_W-1:0]           top_id,
    input  logic [7:0]                top_prio,
    output logic [NUM_SRC-1:0][1:0]   trig,
    output logic [NUM_SRC-1:0][7:0]   prio,
    output logic [NUM_SRC-1:0]        en,
    output logic                      ack_valid,
    output logic [ID_W-1:0]           ack_id,
    output logic [31:0]               rdata
);

    typedef struct packed {
        logic [NUM_SRC-1:0][1:0] trig;
        logic [NUM_SRC-1:0][7:0] prio;
        logic [NUM_SRC-1:0]      en;
        logic [31:0]             rdata;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.rdata = '0;
            for (int i = 0; i < int'(NUM_SRC); i++) begin
                if (addr == trig_addr(i))
                    st_d.rdata[2*(bank_idx(i)%16) +: 2] = st_q.trig[i];
                if (addr == prio_addr(i))
                    st_d.rdata[8*(bank_idx(i)%4) +: 8] = st_q.prio[i];
                if (addr == A_EN + ADDR_W'(i/32))
                    st_d.rdata[i%32] = st_q.en[i];
                if (addr == A_PEND + ADDR_W'(i/32))
                    st_d.rdata[i%32] = pend[i];
            end
            if (addr == A_TOP)
                st_d.rdata = {top_valid, 15'd0, top_prio, 8'(top_id)};
        end
        if (wr_en) begin
            for (int i = 0; i < int'(NUM_SRC); i++) begin
                if (addr == trig_addr(i))
                    st_d.trig[i] = wdata[2*(bank_idx(i)%16) +: 2];
                if (addr == prio_addr(i))
                    st_d.prio[i] = wdata[8*(bank_idx(i)%4) +: 8];
                if (addr == A_EN + ADDR_W'(i/32))
                    st_d.en[i] = wdata[i%32];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig      = st_q.trig;
    assign prio      = st_q.prio;
    assign en        = st_q.en;
    assign rdata     = st_q.rdata;
    assign ack_valid = wr_en && (addr == A_ACK);
    assign ack_id    = wdata[ID_W-1:0];

endmodule

// File: rtl/irqsp_sense.sv
module irqsp_sense
    import irqsp_pkg::*;
#(
    parameter int unsigned NUM_SRC = 48,
    parameter int unsigned ID_W    = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      irq_in,
    input  logic [NUM_SRC-1:0][1:0] trig,
    input  logic                    ack_valid,
    input  logic [ID_W-1:0]         ack_id,
    output logic [NUM_SRC-1:0]      pend
);

    typedef struct packed {
        logic [NUM_SRC-1:0] s1;
        logic [NUM_SRC-1:0] s2;
        logic [NUM_SRC-1:0] s3;
        logic [NUM_SRC-1:0] sticky;
    } sns_t;

    sns_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = irq_in;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        for (int i = 0; i < int'(NUM_SRC); i++) begin
            logic rise, fall, hit, clr;
            rise = st_q.s2[i] & ~st_q.s3[i];
            fall = ~st_q.s2[i] & st_q.s3[i];
            hit  = (trig[i] == SENSE_RISE && rise) || (trig[i] == SENSE_FALL && fall);
            clr  = ack_valid && (ack_id == ID_W'(i));
            if (trig[i][1]) st_d.sticky[i] = hit | (st_q.sticky[i] & ~clr);
            else            st_d.sticky[i] = 1'b0;
            pend[i] = trig[i][1] ? st_q.sticky[i] : (st_q.s2[i] ^ trig[i][0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/irqsp_arbiter.sv
module irqsp_arbiter #(
    parameter int unsigned NUM_SRC = 48,
    parameter int unsigned ID_W    = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      pend,
    input  logic [NUM_SRC-1:0]      en,
    input  logic [NUM_SRC-1:0][7:0] prio,
    output logic                    top_valid,
    output logic [ID_W-1:0]         top_id,
    output logic [7:0]              top_prio
);

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
        logic [7:0]      prio;
    } win_t;

    localparam win_t WIN_NONE = '{valid: 1'b0, id: '1, prio: 8'd0};

    win_t st_d, st_q;

    always_comb begin
        st_d = WIN_NONE;
        for (int i = 0; i < int'(NUM_SRC); i++) begin
            if (pend[i] && en[i] && (!st_d.valid || prio[i] > st_d.prio)) begin
                st_d.valid = 1'b1;
                st_d.id    = ID_W'(i);
                st_d.prio  = prio[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WIN_NONE;
        else        st_q <= st_d;
    end

    assign top_valid = st_q.valid;
    assign top_id    = st_q.id;
    assign top_prio  = st_q.prio;

endmodule

// File: rtl/irqsp_top.sv
module irqsp_top
    import irqsp_pkg::*;
#(
    parameter int unsigned NUM_SRC = 48,
    localparam int unsigned ID_W   = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [7:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic               top_valid,
    output logic [ID_W-1:0]    top_id,
    output logic [7:0]         top_prio
);

    logic [NUM_SRC-1:0][1:0] trig_w;
    logic [NUM_SRC-1:0][7:0] prio_w;
    logic [NUM_SRC-1:0]      en_w;
    logic [NUM_SRC-1:0]      pend_w;
    logic                    ack_valid_w;
    logic [ID_W-1:0]         ack_id_w;

    irqsp_cfg_regs #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .pend(pend_w),
        .top_valid(top_valid), .top_id(top_id), .top_prio(top_prio),
        .trig(trig_w), .prio(prio_w), .en(en_w),
        .ack_valid(ack_valid_w), .ack_id(ack_id_w), .rdata(rdata)
    );

    irqsp_sense #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) sense_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig(trig_w),
        .ack_valid(ack_valid_w), .ack_id(ack_id_w), .pend(pend_w)
    );

    irqsp_arbiter #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) arb_i (
        .clk(clk), .rst_n(rst_n), .pend(pend_w), .en(en_w), .prio(prio_w),
        .top_valid(top_valid), .top_id(top_id), .top_prio(top_prio)
    );

endmodule

// File: rtl/irqsp_checker.sv
module irqsp_checker #(
    parameter int unsigned NUM_SRC = 48,
    parameter int unsigned ID_W    = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic                    rd_en,
    input logic [31:0]             rdata,
    input logic                    top_valid,
    input logic [ID_W-1:0]         top_id,
    input logic [7:0]              top_prio,
    input logic [NUM_SRC-1:0][1:0] trig_w,
    input logic [NUM_SRC-1:0][7:0] prio_w,
    input logic [NUM_SRC-1:0]      en_w,
    input logic [NUM_SRC-1:0]      pend_w
);

    logic [NUM_SRC-1:0][7:0] prio_p;
    logic [NUM_SRC-1:0]      en_p;
    logic [NUM_SRC-1:0]      pend_p;
    logic                    winner_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_p <= '0;
            en_p   <= '0;
            pend_p <= '0;
        end else begin
            prio_p <= prio_w;
            en_p   <= en_w;
            pend_p <= pend_w;
        end
    end

    always_comb begin
        winner_ok = 1'b0;
        for (int i = 0; i < int'(NUM_SRC); i++)
            if (top_id == ID_W'(i))
                winner_ok = en_p[i] && pend_p[i] && (prio_p[i] == top_prio);
    end

    assert_idle_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !top_valid |-> (top_id == '1 && top_prio == 8'd0));

    assert_winner_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> winner_ok);

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sticky
        assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_w[g][1] && pend_w[g] && !wr_en) |=> pend_w[g]);
    end

endmodule

bind irqsp_top irqsp_checker #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .top_valid(top_valid), .top_id(top_id), .top_prio(top_prio),
    .trig_w(trig_w), .prio_w(prio_w), .en_w(en_w), .pend_w(pend_w)
);

// File: tb/irqsp_top_tb_top.sv
`timescale 1ns/1ps
module irqsp_top_tb_top;

    localparam int NSRC = 48;
    localparam int IDW  = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_in = '0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [7:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            top_valid;
    logic [IDW-1:0]  top_id;
    logic [7:0]      top_prio;

    always #2.5 clk = ~clk;

    irqsp_top #(.NUM_SRC(NSRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .top_valid(top_valid), .top_id(top_id), .top_prio(top_prio)
    );

    typedef struct {
        bit          is_top;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 0;

    function automatic logic [31:0] pack_top(bit v, int id, int p);
        return {v, 15'd0, 8'(p), 8'(id)};
    endfunction

    // Monitor: pops expectations and compares against the outputs.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_top ? {top_valid, 15'd0, top_prio, 2'b00, top_id} : rdata;
                n_vec++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%08h expected=%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(bit is_top, logic [31:0] exp, string tag);
        item_t it;
        it.is_top = is_top; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        push(1'b0, exp, tag);
    endtask

    task automatic top_check(bit v, int id, int p, string tag);
        @(negedge clk);
        push(1'b1, pack_top(v, id, p), tag);
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_line(int n, logic v);
        @(negedge clk);
        irq_in[n] = v;
        settle(5);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(2);

        // R1 reset state
        top_check(0, 63, 0, "R1 winner after reset");
        rd_check(8'h00, 32'h0, "R1 local sense word");
        rd_check(8'h08, 32'h0, "R1 local priority word");
        rd_check(8'h60, 32'h0, "R1 enable word");

        // R7 priority packing, R10 readback
        wr(8'h08, 32'h2000_0000);              // source 3 -> 0x20
        wr(8'h09, 32'h0000_2000);              // source 5 -> 0x20
        wr(8'h42, 32'h0000_0040);              // source 40 (common 8) -> 0x40
        rd_check(8'h08, 32'h2000_0000, "R7 local prio pack src3");
        rd_check(8'h42, 32'h0000_0040, "R7 common prio pack src40");
        wr(8'h60, 32'h0000_0028);              // enable 3,5
        wr(8'h61, 32'h0000_0100);              // enable 40
        rd_check(8'h61, 32'h0000_0100, "R9 enable word 1 readback");

        // R2 level high, R8 ties and priority
        set_line(3, 1);
        top_check(1, 3, 8'h20, "R2 level high src3");
        set_line(5, 1);
        top_check(1, 3, 8'h20, "R8 tie lowest id");
        set_line(40, 1);
        top_check(1, 40, 8'h40, "R8 larger priority wins");
        set_line(40, 0);
        top_check(1, 3, 8'h20, "R8 fallback after drop");

        // R2 level low on src5, R6 packing
        wr(8'h00, 32'h0000_0400);
        rd_check(8'h00, 32'h0000_0400, "R6 local sense pack src5");
        set_line(3, 0);
        top_check(0, 63, 0, "R2 level low inactive when line high");
        set_line(5, 0);
        top_check(1, 5, 8'h20, "R2 level low active when line low");

        // R9 disabled source
        wr(8'h60, 32'h0000_0008);
        settle(3);
        top_check(0, 63, 0, "R9 disabled never wins");
        rd_check(8'h68, 32'h0000_0020, "R9 pending visible while disabled");

        // R3 rising edge sticky on common src40
        wr(8'h20, 32'h0002_0000);
        rd_check(8'h20, 32'h0002_0000, "R6 common sense pack src40");
        @(negedge clk); irq_in[40] = 1'b1;
        @(negedge clk); irq_in[40] = 1'b0;
        settle(5);
        top_check(1, 40, 8'h40, "R3 rising edge latched");
        wr(8'h70, 32'd3);
        settle(3);
        top_check(1, 40, 8'h40, "R5 ack of other id ignored");
        wr(8'h70, 32'd40);
        settle(3);
        top_check(0, 63, 0, "R3 ack clears sticky");

        // R4 falling edge on src3
        wr(8'h00, 32'h0000_04C0);
        set_line(3, 1);
        top_check(0, 63, 0, "R4 rising ignored in falling mode");
        set_line(3, 0);
        top_check(1, 3, 8'h20, "R4 falling edge latched");
        wr(8'h60, 32'h0000_0028);
        settle(3);
        top_check(1, 3, 8'h20, "R8 tie edge vs level");
        wr(8'h70, 32'd5);
        settle(3);
        rd_check(8'h68, 32'h0000_0028, "R5 ack on level source no effect");
        wr(8'h70, 32'd3);
        settle(3);
        top_check(1, 5, 8'h20, "R5 ack clears src3 only");

        // R7 full range
        wr(8'h42, 32'h0000_00FF);
        wr(8'h20, 32'h0000_0000);
        set_line(40, 1);
        top_check(1, 40, 8'hFF, "R7 priority 255");
        rd_check(8'h71, 32'h8000_FF28, "R10 winner word");

        // R11 latency
        @(negedge clk); irq_in[40] = 1'b0;
        wr(8'h61, 32'h0);
        wr(8'h60, 32'h0000_0C00);              // enable 10, 11
        wr(8'h0A, 32'h0201_0000);              // src10 -> 1, src11 -> 2
        wr(8'h00, 32'h0080_0000);              // src11 rising, others level high
        settle(4);
        top_check(0, 63, 0, "R11 idle before stimulus");
        @(negedge clk); irq_in[10] = 1'b1;
        @(negedge clk);
        top_check(0, 63, 0, "R11 level not yet after two edges");
        top_check(1, 10, 1, "R11 level after three edges");
        settle(2);
        @(negedge clk); irq_in[11] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        top_check(1, 10, 1, "R11 edge not yet after three edges");
        top_check(1, 11, 2, "R11 edge after four edges");

        settle(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule